// File: doc/BRIEF.md
# Word-Mark Receive Aligner

This block finds and holds the word boundary on a die-to-die receive path that carries full-rate words as two half-rate beats. On the transmit side, a small inserter forces a fixed two-bit mark into each outgoing 80-bit word while marking is switched on. On the receive side, beats arrive one per valid cycle. The aligner watches every pair of adjacent beats for the mark. Once it has seen the mark at one beat phase often enough, it raises an aligned flag and from then on delivers whole 80-bit words at that phase.

After lock the aligner stops searching, and the boundary cannot move. If the transmitter has gone back to carrying data in the mark bits, a check-enable input turns off mark checking. While checking is on, a word whose mark bits read wrong drops the aligned flag, and the search starts again. In single-width operation, alignment is switched off. Words are then cut at a phase fixed by reset, and the aligned flag stays low.

Top module: `mark_word_aligner`

## Requirements
- R1: While reset is held and on the first cycle after it, `alignDone`, `rxWordValid` and `txMarkedValid` are 0.
- R2: With `markEn` high, a word accepted on `txWord` appears on `txMarked` one cycle later. In it, bit 79 is forced to 1 and bit 39 is forced to 0, and all other bits are unchanged. `txMarkedValid` follows `txValid` with the same one-cycle delay.
- R3: With `markEn` low, `txMarked` equals the accepted word unchanged.
- R4: A beat pair matches when the older beat has bit 39 = 0 and the newer beat has bit 39 = 1. With `alignEn` high, `alignDone` rises one cycle after the fourth consecutive matching pair seen at the same beat phase.
- R5: A non-matching pair at the candidate phase clears the match count, so four fresh matching pairs are needed afterwards.
- R6: After lock, the word that completed the lock is not delivered. After that, every pair ending at the locked phase is delivered one cycle after its second beat as `rxWord = {newer beat, older beat}`, with `rxWordValid` high for one cycle.
- R7: While locked with `chkEn` low, words whose mark bits carry any data are delivered and leave `alignDone` high.
- R8: While locked with `chkEn` high, a pair at the locked phase that does not match drops `alignDone`, is not delivered, and restarts the search. No word is delivered until the aligner locks again.
- R9: With `alignEn` low, `alignDone` stays 0. Every second valid beat counted from reset completes a word, which is delivered without any mark check.
- R10: Lock is found at either beat phase, including a stream that starts one beat off the word boundary.
- R11: Cycles with `rxBeatValid` low deliver no word, do not advance the beat phase, and do not break a match run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| markEn | input | 1 | Insert the mark into transmitted words |
| txWord | input | 80 | Word to be marked |
| txValid | input | 1 | `txWord` is valid |
| txMarked | output | 80 | Word with the mark applied |
| txMarkedValid | output | 1 | `txMarked` is valid |
| alignEn | input | 1 | Double-width mode, alignment active |
| chkEn | input | 1 | Check the mark bits after lock |
| rxBeat | input | 40 | Received half-rate beat |
| rxBeatValid | input | 1 | `rxBeat` is valid |
| rxWord | output | 80 | Assembled word, newer beat in the upper half |
| rxWordValid | output | 1 | `rxWord` is valid |
| alignDone | output | 1 | Word boundary locked |

## Verification
The bench builds the block with its default parameters: 40-bit beats and a lock run of four pairs. With these values the short directed streams reach every state. It can lock at both beat phases, break a run after three matches, and lose lock through a checked violation. It can also survive data carried in the mark bits with checking off, hold the phase across idle gaps, and run unaligned single-width framing.

// File: rtl/mwa_pkg.sv
package mwa_pkg;
  // strobes the receive control hands to the receive datapath
  typedef struct packed {
    logic wordEmit;  // current beat closes a word that must be delivered
  } mwaStrobe_t;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } mwaState_t;
endpackage

// File: rtl/mwa_tx_marker.sv
module mwa_tx_marker #(
  parameter int BEAT_W = 40
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  markEn,
  input  logic [2*BEAT_W-1:0]   txWord,
  input  logic                  txValid,
  output logic [2*BEAT_W-1:0]   txMarked,
  output logic                  txMarkedValid
);
  localparam int WORD_W = 2 * BEAT_W;
  localparam int MARK_HI = WORD_W - 1;
  localparam int MARK_LO = BEAT_W - 1;

  logic [WORD_W-1:0] markedNext;

  always_comb begin
    markedNext = txWord;
    if (markEn) begin
      markedNext[MARK_HI] = 1'b1;
      markedNext[MARK_LO] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txMarked      <= '0;
      txMarkedValid <= 1'b0;
    end else begin
      txMarkedValid <= txValid;
      if (txValid) txMarked <= markedNext;
    end
  end
endmodule

// File: rtl/mwa_rx_datapath.sv
module mwa_rx_datapath
  import mwa_pkg::*;
#(
  parameter int BEAT_W = 40
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BEAT_W-1:0]     rxBeat,
  input  logic                  rxBeatValid,
  input  mwaStrobe_t            strobe,
  output logic                  beatParity,
  output logic                  markMatch,
  output logic [2*BEAT_W-1:0]   rxWord,
  output logic                  rxWordValid
);
  localparam int WORD_W = 2 * BEAT_W;
  localparam int MARK_BIT = BEAT_W - 1;

  logic [BEAT_W-1:0] prevBeat;

  // older beat carries the low mark, newer beat the high mark
  assign markMatch = rxBeat[MARK_BIT] & ~prevBeat[MARK_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevBeat    <= '0;
      beatParity  <= 1'b0;
      rxWord      <= '0;
      rxWordValid <= 1'b0;
    end else begin
      rxWordValid <= rxBeatValid & strobe.wordEmit;
      if (rxBeatValid) begin
        prevBeat   <= rxBeat;
        beatParity <= ~beatParity;
        if (strobe.wordEmit) rxWord <= {rxBeat, prevBeat};
      end
    end
  end

  logic [WORD_W-1:0] unusedW;
  assign unusedW = '0;
endmodule

// File: rtl/mwa_rx_control.sv
module mwa_rx_control
  import mwa_pkg::*;
#(
  parameter int LOCK_PAIRS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       alignEn,
  input  logic       chkEn,
  input  logic       beatValid,
  input  logic       beatParity,
  input  logic       markMatch,
  output mwaStrobe_t strobe,
  output logic       alignDone
);
  localparam int RUN_W = $clog2(LOCK_PAIRS + 1);
  localparam logic [RUN_W-1:0] LAST_RUN = RUN_W'(LOCK_PAIRS - 1);

  mwaState_t        state;
  logic [RUN_W-1:0] runCnt;
  logic             candPar;
  logic             lockPar;
  logic             onLockPhase;
  logic             violation;
  logic             wordBeat;

  assign onLockPhase = (state == ST_LOCKED) && (beatParity == lockPar);
  assign violation   = alignEn && beatValid && onLockPhase && chkEn && !markMatch;
  assign wordBeat    = beatValid && (alignEn ? onLockPhase : beatParity);
  assign strobe.wordEmit = wordBeat && !violation;
  assign alignDone   = (state == ST_LOCKED);

  always_ff @(posedge clk) begin
    if (!rstN || !alignEn) begin
      state   <= ST_SEARCH;
      runCnt  <= '0;
      candPar <= 1'b0;
      lockPar <= 1'b0;
    end else if (beatValid) begin
      case (state)
        ST_SEARCH: begin
          if (markMatch) begin
            if (runCnt != '0 && beatParity == candPar) begin
              if (runCnt == LAST_RUN) begin
                state   <= ST_LOCKED;
                lockPar <= beatParity;
                runCnt  <= '0;
              end else begin
                runCnt <= runCnt + 1'b1;
              end
            end else begin
              candPar <= beatParity;
              runCnt  <= RUN_W'(1);
            end
          end else if (beatParity == candPar) begin
            runCnt <= '0;
          end
        end
        ST_LOCKED: begin
          if (violation) begin
            state  <= ST_SEARCH;
            runCnt <= '0;
          end
        end
        default: state <= ST_SEARCH;
      endcase
    end
  end
endmodule

// File: rtl/mark_word_aligner.sv
module mark_word_aligner
  import mwa_pkg::*;
#(
  parameter int BEAT_W     = 40,
  parameter int LOCK_PAIRS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                markEn,
  input  logic [2*BEAT_W-1:0] txWord,
  input  logic                txValid,
  output logic [2*BEAT_W-1:0] txMarked,
  output logic                txMarkedValid,
  input  logic                alignEn,
  input  logic                chkEn,
  input  logic [BEAT_W-1:0]   rxBeat,
  input  logic                rxBeatValid,
  output logic [2*BEAT_W-1:0] rxWord,
  output logic                rxWordValid,
  output logic                alignDone
);
  mwaStrobe_t strobe;
  logic       beatParity;
  logic       markMatch;

  mwa_tx_marker #(.BEAT_W(BEAT_W)) tx_i (
    .clk(clk), .rstN(rstN), .markEn(markEn), .txWord(txWord), .txValid(txValid),
    .txMarked(txMarked), .txMarkedValid(txMarkedValid)
  );

  mwa_rx_datapath #(.BEAT_W(BEAT_W)) dp_i (
    .clk(clk), .rstN(rstN), .rxBeat(rxBeat), .rxBeatValid(rxBeatValid),
    .strobe(strobe), .beatParity(beatParity), .markMatch(markMatch),
    .rxWord(rxWord), .rxWordValid(rxWordValid)
  );

  mwa_rx_control #(.LOCK_PAIRS(LOCK_PAIRS)) ctl_i (
    .clk(clk), .rstN(rstN), .alignEn(alignEn), .chkEn(chkEn),
    .beatValid(rxBeatValid), .beatParity(beatParity), .markMatch(markMatch),
    .strobe(strobe), .alignDone(alignDone)
  );
endmodule

// File: rtl/mark_word_aligner_chk.sv
module mark_word_aligner_chk #(
  parameter int BEAT_W = 40
) (
  input logic                clk,
  input logic                rstN,
  input logic                markEn,
  input logic                txValid,
  input logic [2*BEAT_W-1:0] txMarked,
  input logic                txMarkedValid,
  input logic                alignEn,
  input logic [BEAT_W-1:0]   rxBeat,
  input logic                rxBeatValid,
  input logic                rxWordValid,
  input logic                alignDone
);
  localparam int MARK_HI = 2 * BEAT_W - 1;
  localparam int MARK_LO = BEAT_W - 1;

  // R2
  tx_mark_applied_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txMarkedValid && $past(markEn)) |-> (txMarked[MARK_HI] && !txMarked[MARK_LO]));

  // R2
  tx_valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    txMarkedValid |-> $past(txValid));

  // R4
  lock_on_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alignDone) |-> $past(rxBeatValid && rxBeat[MARK_LO]));

  // R9
  no_lock_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !alignEn |=> !alignDone);

  // R11
  idle_no_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxBeatValid |=> !rxWordValid);
endmodule

bind mark_word_aligner mark_word_aligner_chk #(.BEAT_W(BEAT_W)) chk_i (
  .clk(clk), .rstN(rstN), .markEn(markEn), .txValid(txValid), .txMarked(txMarked),
  .txMarkedValid(txMarkedValid), .alignEn(alignEn), .rxBeat(rxBeat),
  .rxBeatValid(rxBeatValid), .rxWordValid(rxWordValid), .alignDone(alignDone)
);

// File: tb/mark_word_aligner_tb_top.sv
module mark_word_aligner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 40;
  localparam int WW = 80;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          markEn = 1'b0;
  logic [WW-1:0] txWord = '0;
  logic          txValid = 1'b0;
  logic [WW-1:0] txMarked;
  logic          txMarkedValid;
  logic          alignEn = 1'b0;
  logic          chkEn = 1'b0;
  logic [BW-1:0] rxBeat = '0;
  logic          rxBeatValid = 1'b0;
  logic [WW-1:0] rxWord;
  logic          rxWordValid;
  logic          alignDone;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mark_word_aligner dut_i (
    .clk(clk), .rstN(rstN), .markEn(markEn), .txWord(txWord), .txValid(txValid),
    .txMarked(txMarked), .txMarkedValid(txMarkedValid), .alignEn(alignEn),
    .chkEn(chkEn), .rxBeat(rxBeat), .rxBeatValid(rxBeatValid), .rxWord(rxWord),
    .rxWordValid(rxWordValid), .alignDone(alignDone)
  );

  task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] mk(input logic [WW-1:0] d);
    logic [WW-1:0] r = d;
    r[WW-1] = 1'b1;
    r[BW-1] = 1'b0;
    return r;
  endfunction

  task automatic doReset();
    rstN = 1'b0; rxBeatValid = 1'b0; txValid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic sendBeat(input logic [BW-1:0] b);
    rxBeat = b; rxBeatValid = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic idleBeat();
    rxBeatValid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic sendWord(input logic [WW-1:0] w);
    sendBeat(w[BW-1:0]);
    sendBeat(w[WW-1:BW]);
  endtask

  task automatic testReset();
    rstN = 1'b0; txValid = 1'b1; rxBeatValid = 1'b1; alignEn = 1'b1;
    repeat (2) @(posedge clk); #1;
    check("R1 alignDone in reset", WW'(alignDone), '0);
    check("R1 rxWordValid in reset", WW'(rxWordValid), '0);
    check("R1 txMarkedValid in reset", WW'(txMarkedValid), '0);
    rxBeatValid = 1'b0; txValid = 1'b0;
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 alignDone after reset", WW'(alignDone), '0);
  endtask

  task automatic testTx();
    logic [WW-1:0] w = 80'hFFFF_FFFF_FFFF_FFFF_FFFF;
    doReset();
    markEn = 1'b1; txWord = w; txValid = 1'b1;
    @(posedge clk); #1;
    check("R2 marked word", txMarked, mk(w));
    check("R2 valid delay", WW'(txMarkedValid), 80'd1);
    w = 80'h0123_4567_89AB_CDEF_0F1E;
    txWord = w;
    @(posedge clk); #1;
    check("R2 marked pattern", txMarked, mk(w));
    markEn = 1'b0; w = 80'h7FFF_0000_80FF_0000_1234;
    txWord = w;
    @(posedge clk); #1;
    check("R3 passthrough", txMarked, w);
    txValid = 1'b0;
    @(posedge clk); #1;
    check("R2 valid drops", WW'(txMarkedValid), '0);
  endtask

  task automatic testLockAndLoss();
    logic [WW-1:0] w;
    doReset();
    alignEn = 1'b1; chkEn = 1'b1;
    for (int i = 0; i < 3; i++) sendWord(mk(80'h1000 + WW'(i)));
    check("R4 not locked after three", WW'(alignDone), '0);
    sendWord(mk(80'h2000));
    check("R4 locked after four", WW'(alignDone), 80'd1);
    check("R6 lock word not delivered", WW'(rxWordValid), '0);
    w = mk(80'hABCD_EF01_2345_6789_0ACE);
    sendBeat(w[BW-1:0]);
    check("R6 no word mid pair", WW'(rxWordValid), '0);
    sendBeat(w[WW-1:BW]);
    check("R6 word valid", WW'(rxWordValid), 80'd1);
    check("R6 word data", rxWord, w);
    // mark bits reused for data with checking off
    chkEn = 1'b0;
    w = 80'h5555_0000_00AA_FFFF_1111;
    w[WW-1] = 1'b0; w[BW-1] = 1'b1;
    sendWord(w);
    check("R7 alignDone kept", WW'(alignDone), 80'd1);
    check("R7 data word delivered", rxWord, w);
    // checked violation
    chkEn = 1'b1;
    w = 80'h0000_1111_2222_3333_4444;
    sendWord(w);
    check("R8 alignDone dropped", WW'(alignDone), '0);
    check("R8 violating word not delivered", WW'(rxWordValid), '0);
    sendWord(mk(80'h9999));
    check("R8 searching delivers nothing", WW'(rxWordValid), '0);
  endtask

  task automatic testRunBreak();
    doReset();
    alignEn = 1'b1; chkEn = 1'b1;
    for (int i = 0; i < 3; i++) sendWord(mk(80'h300 + WW'(i)));
    sendWord(80'h0000_0000_0000_0000_0042);
    for (int i = 0; i < 3; i++) sendWord(mk(80'h400 + WW'(i)));
    check("R5 run cleared by break", WW'(alignDone), '0);
    sendWord(mk(80'h500));
    check("R5 lock after fresh run", WW'(alignDone), 80'd1);
  endtask

  task automatic testOddPhase();
    logic [WW-1:0] w = mk(80'hCAFE_0000_BEEF_0000_0001);
    doReset();
    alignEn = 1'b1; chkEn = 1'b1;
    sendBeat(40'h00_0000_0077);
    for (int i = 0; i < 4; i++) sendWord(mk(80'h600 + WW'(i)));
    check("R10 locked at odd phase", WW'(alignDone), 80'd1);
    sendWord(w);
    check("R10 word valid", WW'(rxWordValid), 80'd1);
    check("R10 word data", rxWord, w);
  endtask

  task automatic testIdle();
    logic [WW-1:0] w = mk(80'h1357_9BDF_2468_ACE0_FFFF);
    doReset();
    alignEn = 1'b1; chkEn = 1'b1;
    for (int i = 0; i < 4; i++) begin
      logic [WW-1:0] m = mk(80'h700 + WW'(i));
      sendBeat(m[BW-1:0]); idleBeat(); sendBeat(m[WW-1:BW]); idleBeat();
    end
    check("R11 locked across gaps", WW'(alignDone), 80'd1);
    sendBeat(w[BW-1:0]); idleBeat();
    check("R11 no word on idle", WW'(rxWordValid), '0);
    sendBeat(w[WW-1:BW]);
    check("R11 word after gap", rxWord, w);
    check("R11 word valid after gap", WW'(rxWordValid), 80'd1);
  endtask

  task automatic testSingle();
    logic [WW-1:0] w = mk(80'h8888_7777_6666_5555_4444);
    doReset();
    alignEn = 1'b0; chkEn = 1'b1;
    for (int i = 0; i < 4; i++) sendWord(mk(80'h800 + WW'(i)));
    check("R9 no lock when disabled", WW'(alignDone), '0);
    sendBeat(w[BW-1:0]);
    check("R9 no word on first beat", WW'(rxWordValid), '0);
    sendBeat(w[WW-1:BW]);
    check("R9 word on second beat", rxWord, w);
    w = 80'h0000_0000_0000_0000_1234;
    sendWord(w);
    check("R9 unmarked word delivered", rxWord, w);
    check("R9 unmarked word valid", WW'(rxWordValid), 80'd1);
  endtask

  initial begin
    testReset();
    testTx();
    testLockAndLoss();
    testRunBreak();
    testOddPhase();
    testIdle();
    testSingle();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule